// File: doc/BRIEF.md
# PCM Codec Clock Mode Selector

This block settles how the receive half of a PCM codec is clocked. It decides between synchronous operation, where the receive side borrows the transmit master clock and bit clock, and asynchronous operation, where the receive side runs from its own clocks. It also decides which master-clock rate the internal dividers assume, and it produces an 8 kHz frame tick by dividing the transmit master clock.

The pin that carries the receive bit clock also serves as a static rate select. The block tells the two uses apart by watching for edges: an edge inside a configurable window means the pin is a clock, and asynchronous mode is taken. A full window with no edge means the pin is read as a level again. The pin that can carry the receive master clock is passed to the receive side only while asynchronous mode is active and that pin is itself toggling. All pins are sampled by a fast system clock `clk`. Clock routing is modelled as a multiplexer whose select comes from registers.

Frame length is 256 master clocks at 2.048 MHz and 192 at 1.536 MHz. At 1.544 MHz the divider holds for one extra master clock each frame, so a frame lasts 193 master clocks. A rising frame-sync edge restarts the frame at any time.

Top module: `pcm_clk_mode_sel`

## Requirements
- R1: After reset with a static select pin, `async_o` is 0 and `frame_tick_o` is 0.
- R2: While `async_o` is 0, `rx_bclk_o` follows `bclkx_i` and `rx_mclk_o` follows `mclkx_i`.
- R3: While `async_o` is 0, `freq_code_o` is the native rate when `rbclk_sel_i` is 1 and the alternate rate when it is 0. Codes: 0 = 2.048 MHz, 1 = 1.536 MHz, 2 = 1.544 MHz. The native rate is 2.048 MHz when `native_2048_i` is 1; otherwise it is 1.544 MHz when `t1_rate_i` is 1 and 1.536 MHz when it is 0.
- R4: Any edge on `rbclk_sel_i` sets `async_o` on the following `clk` edge.
- R5: While `async_o` is 1, `rx_bclk_o` follows `rbclk_sel_i` and `freq_code_o` is the native rate, whatever the pin level.
- R6: `rx_mclk_o` follows `mclkr_pdn_i` only while `async_o` is 1 and `mclkr_pdn_i` has toggled within the window. Otherwise it follows `mclkx_i`, even when `mclkr_pdn_i` toggles in synchronous mode.
- R7: Once `rbclk_sel_i` stops toggling, `async_o` stays 1 for `ACT_WINDOW` `clk` edges after the last edge, then returns to 0.
- R8: With no frame sync, `frame_tick_o` pulses for one `clk` cycle every 256 rising edges of `mclkx_i` at code 0 and every 192 at code 1.
- R9: At code 2, the divider holds for one rising edge per frame, so ticks come every 193 rising edges of `mclkx_i`.
- R10: A rising edge on `fsx_i` restarts the frame. `frame_tick_o` pulses in the next cycle, and the following tick comes a full frame of master-clock rising edges later.
- R11: `freq_code_o` never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| mclkx_i | input | 1 | Transmit master clock (sampled level) |
| bclkx_i | input | 1 | Transmit bit clock |
| mclkr_pdn_i | input | 1 | Receive master clock, or grounded for synchronous use |
| rbclk_sel_i | input | 1 | Receive bit clock, or static rate select |
| native_2048_i | input | 1 | Strap: native rate is 2.048 MHz |
| t1_rate_i | input | 1 | Strap: the lower-rate family uses 1.544 MHz instead of 1.536 MHz |
| fsx_i | input | 1 | Transmit frame sync |
| rx_mclk_o | output | 1 | Master clock routed to the receive section |
| rx_bclk_o | output | 1 | Bit clock routed to the receive section |
| async_o | output | 1 | 1 = asynchronous mode |
| freq_code_o | output | 2 | Assumed master-clock rate code |
| frame_tick_o | output | 1 | One-cycle 8 kHz frame pulse |

## Verification
The hardest condition to reach is an exact count of master-clock edges between a frame-sync restart and the next tick, because the sync edge can land on a cycle with or without a master-clock rise. The stimulus toggles `mclkx_i` on every step and raises `fsx_i` only in the step where `mclkx_i` also rises. The restart therefore absorbs that rise, and the next tick is expected exactly 2·frame-length steps later. Reverting to a static read needs a quiet window of precise length. The bench stops toggling the select pin and probes just inside and just past `ACT_WINDOW`.

// File: rtl/pcm_clk_pkg.sv
package pcm_clk_pkg;

    typedef enum logic [1:0] {
        FQ_2048 = 2'd0,
        FQ_1536 = 2'd1,
        FQ_1544 = 2'd2
    } freq_e;

    localparam int PH_W = 8;

    typedef struct packed {
        logic async_mode;
        logic mclkr_live;
    } route_sel_t;

    function automatic freq_e pick_freq(logic async_mode, logic sel_pin,
                                        logic native_2048, logic t1_rate);
        logic use_2048;
        use_2048 = (async_mode || sel_pin) ? native_2048 : !native_2048;
        if (use_2048)
            return FQ_2048;
        return t1_rate ? FQ_1544 : FQ_1536;
    endfunction

    function automatic logic [PH_W-1:0] last_phase(freq_e f);
        return (f == FQ_2048) ? 8'd255 : 8'd191;
    endfunction

endpackage

// File: rtl/clk_activity_det.sv
module clk_activity_det #(
    parameter int WINDOW = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    output logic active_o
);
    localparam int CW = $clog2(WINDOW + 1);
    localparam logic [CW-1:0] LIM = CW'(WINDOW - 1);

    logic          prev_q;
    logic [CW-1:0] quiet_q;
    logic          active_q;
    logic          edge_seen;

    assign edge_seen = sig_i ^ prev_q;
    assign active_o  = active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= sig_i;
            quiet_q  <= LIM;
            active_q <= 1'b0;
        end else begin
            prev_q <= sig_i;
            if (edge_seen) begin
                quiet_q  <= '0;
                active_q <= 1'b1;
            end else if (quiet_q >= LIM) begin
                active_q <= 1'b0;
            end else begin
                quiet_q <= quiet_q + 1'b1;
            end
        end
    end

    assert_edge_sets_R4: assert property (@(posedge clk) disable iff (rst)
        edge_seen |=> active_q);

    assert_quiet_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (active_q && !edge_seen && quiet_q < LIM) |=> active_q);

endmodule

// File: rtl/frame_divider.sv
module frame_divider
    import pcm_clk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  mclk_i,
    input  logic  fsx_i,
    input  freq_e freq_i,
    output logic  tick_o
);
    logic [PH_W-1:0] phase_q;
    logic            held_q;
    logic            tick_q;
    logic            mprev_q;
    logic            fprev_q;
    logic            mclk_rise;
    logic            fsx_rise;
    logic [PH_W-1:0] last;

    assign mclk_rise = mclk_i & ~mprev_q;
    assign fsx_rise  = fsx_i & ~fprev_q;
    assign last      = last_phase(freq_i);
    assign tick_o    = tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            held_q  <= 1'b0;
            tick_q  <= 1'b0;
            mprev_q <= mclk_i;
            fprev_q <= fsx_i;
        end else begin
            mprev_q <= mclk_i;
            fprev_q <= fsx_i;
            tick_q  <= 1'b0;
            if (fsx_rise) begin
                phase_q <= '0;
                held_q  <= 1'b0;
                tick_q  <= 1'b1;
            end else if (mclk_rise) begin
                if (phase_q >= last) begin
                    if (freq_i == FQ_1544 && !held_q) begin
                        held_q <= 1'b1;
                    end else begin
                        phase_q <= '0;
                        held_q  <= 1'b0;
                        tick_q  <= 1'b1;
                    end
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end
        end
    end

    assert_tick_at_start_R8: assert property (@(posedge clk) disable iff (rst)
        tick_q |-> (phase_q == '0));

    assert_tick_clears_hold_R9: assert property (@(posedge clk) disable iff (rst)
        tick_q |-> !held_q);

    assert_sync_restart_R10: assert property (@(posedge clk) disable iff (rst)
        fsx_rise |=> tick_q);

endmodule

// File: rtl/pcm_clk_mode_sel.sv
module pcm_clk_mode_sel
    import pcm_clk_pkg::*;
#(
    parameter int ACT_WINDOW = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mclkx_i,
    input  logic       bclkx_i,
    input  logic       mclkr_pdn_i,
    input  logic       rbclk_sel_i,
    input  logic       native_2048_i,
    input  logic       t1_rate_i,
    input  logic       fsx_i,
    output logic       rx_mclk_o,
    output logic       rx_bclk_o,
    output logic       async_o,
    output logic [1:0] freq_code_o,
    output logic       frame_tick_o
);
    localparam int N_DET = 2;

    logic [N_DET-1:0] watch_sig;
    logic [N_DET-1:0] live;
    route_sel_t       route;
    freq_e            fq;

    assign watch_sig = {mclkr_pdn_i, rbclk_sel_i};

    for (genvar g = 0; g < N_DET; g++) begin : g_det
        clk_activity_det #(.WINDOW(ACT_WINDOW)) u_det (
            .clk      (clk),
            .rst      (rst),
            .sig_i    (watch_sig[g]),
            .active_o (live[g])
        );
    end

    assign route.async_mode = live[0];
    assign route.mclkr_live = live[0] & live[1];

    assign fq          = pick_freq(route.async_mode, rbclk_sel_i, native_2048_i, t1_rate_i);
    assign freq_code_o = fq;
    assign async_o     = route.async_mode;
    assign rx_bclk_o   = route.async_mode ? rbclk_sel_i : bclkx_i;
    assign rx_mclk_o   = route.mclkr_live ? mclkr_pdn_i : mclkx_i;

    frame_divider u_div (
        .clk    (clk),
        .rst    (rst),
        .mclk_i (mclkx_i),
        .fsx_i  (fsx_i),
        .freq_i (fq),
        .tick_o (frame_tick_o)
    );

    assert_sync_route_R2: assert property (@(posedge clk) disable iff (rst)
        !async_o |-> (rx_bclk_o == bclkx_i && rx_mclk_o == mclkx_i));

    assert_async_native_R5: assert property (@(posedge clk) disable iff (rst)
        async_o |-> ((freq_code_o == 2'd0) == native_2048_i));

    assert_mclkr_needs_async_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_mclk_o != mclkx_i) |-> async_o);

    assert_code_legal_R11: assert property (@(posedge clk) disable iff (rst)
        freq_code_o != 2'd3);

endmodule

// File: tb/pcm_clk_mode_sel_tb.sv
module pcm_clk_mode_sel_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mclkx = 1'b0, bclkx = 1'b0, mclkr = 1'b0, sel = 1'b1;
    logic nat = 1'b1, t1 = 1'b0, fsx = 1'b0;
    logic rx_mclk, rx_bclk, async_m, tick;
    logic [1:0] code;

    int checks = 0, fails = 0, since = 0, gap = 0;
    bit tick_seen = 0, done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_clk_mode_sel #(.ACT_WINDOW(WIN)) u_dut (
        .clk(clk), .rst(rst), .mclkx_i(mclkx), .bclkx_i(bclkx),
        .mclkr_pdn_i(mclkr), .rbclk_sel_i(sel), .native_2048_i(nat),
        .t1_rate_i(t1), .fsx_i(fsx), .rx_mclk_o(rx_mclk), .rx_bclk_o(rx_bclk),
        .async_o(async_m), .freq_code_o(code), .frame_tick_o(tick)
    );

    function automatic int exp_code(bit a, bit s, bit n, bit t);
        bit hi;
        hi = (a || s) ? n : !n;
        if (hi) return 0;
        return t ? 2 : 1;
    endfunction

    function automatic int frame_rises(int c);
        return (c == 0) ? 256 : (c == 1) ? 192 : 193;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        mclkx = ~mclkx;
        #1;
        since++;
        tick_seen = tick;
        if (tick_seen) begin
            gap = since;
            since = 0;
        end
    endtask

    task automatic frame_test(bit n, bit t);
        int c, lim;
        nat = n; t1 = t;
        repeat (4) step();
        c = exp_code(0, sel, n, t);
        chk(code == 2'(c), "R3 frame cfg code", code, c);
        while (mclkx != 1'b0) step();
        step();
        fsx = 1'b1;
        step();
        chk(tick == 1'b1, "R10 tick after sync edge", tick, 1);
        step(); step();
        fsx = 1'b0;
        lim = 0;
        do begin step(); lim++; end while (!tick_seen && lim < 600);
        chk(gap == 2*frame_rises(c), (c == 2) ? "R9 R10 first frame" : "R8 R10 first frame",
            gap, 2*frame_rises(c));
        lim = 0;
        do begin step(); lim++; end while (!tick_seen && lim < 600);
        chk(gap == 2*frame_rises(c), (c == 2) ? "R9 steady frame" : "R8 steady frame",
            gap, 2*frame_rises(c));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20241));
        repeat (4) step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk(async_m == 1'b0, "R1 async after reset", async_m, 0);
        chk(tick == 1'b0, "R1 tick after reset", tick, 0);
        chk(code == 2'd0, "R3 code after reset", code, 0);

        // R3 random static selects
        for (int i = 0; i < 10; i++) begin
            nat = 1'($urandom % 2);
            t1  = 1'($urandom % 2);
            sel = 1'($urandom % 2);
            repeat (WIN + 3) step();
            chk(async_m == 1'b0, "R7 static after quiet", async_m, 0);
            chk(code == 2'(exp_code(0, sel, nat, t1)), "R3 static select",
                code, exp_code(0, sel, nat, t1));
        end

        // R2 synchronous routing
        for (int i = 0; i < 16; i++) begin
            bclkx = 1'($urandom % 2);
            #1;
            chk(rx_bclk == bclkx, "R2 rx bit clock", rx_bclk, bclkx);
            chk(rx_mclk == mclkx, "R2 rx master clock", rx_mclk, mclkx);
            step();
        end

        // R6 receive master pin toggling in synchronous mode is not used
        for (int i = 0; i < 8; i++) begin
            mclkr = ~mclkr;
            step();
            chk(rx_mclk == mclkx, "R6 sync ignores mclkr", rx_mclk, mclkx);
        end
        chk(async_m == 1'b0, "R6 still sync", async_m, 0);

        // R4 R5 R6 asynchronous mode
        nat = 1'b0; t1 = 1'b1;
        for (int j = 0; j < 12; j++) begin
            sel = ~sel;
            mclkr = ~mclkr;
            step();
            if (j == 0) chk(async_m == 1'b1, "R4 edge sets async", async_m, 1);
            #1;
            chk(rx_bclk == sel, "R5 async bit clock", rx_bclk, sel);
            chk(code == 2'd2, "R5 async native code", code, 2);
            chk(rx_mclk == mclkr, "R6 async master from mclkr", rx_mclk, mclkr);
        end
        for (int j = 0; j < WIN + 3; j++) begin
            sel = ~sel;
            step();
        end
        chk(async_m == 1'b1, "R4 still async", async_m, 1);
        chk(rx_mclk == mclkx, "R6 quiet mclkr falls back", rx_mclk, mclkx);

        // R7 revert timing
        repeat (WIN - 2) step();
        chk(async_m == 1'b1, "R7 async inside window", async_m, 1);
        repeat (4) step();
        chk(async_m == 1'b0, "R7 reverts after window", async_m, 0);

        // R8 R9 R10 frame divider
        sel = 1'b1;
        repeat (WIN + 3) step();
        frame_test(1'b1, 1'b0);
        frame_test(1'b0, 1'b0);
        frame_test(1'b0, 1'b1);
        chk(code != 2'd3, "R11 legal code", code, 2);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule